// File: doc/BRIEF.md
# Phase-correct PWM timer

This block is an 8-bit timer/counter that generates a symmetric, center-aligned pulse-width waveform. On every enabled timer tick the counter steps by one. It climbs from zero to its ceiling of 255, turns around and descends to zero, then climbs again, so that one full period is 510 ticks. A compare unit watches for the count to equal a programmed threshold. What it does to the waveform at that moment depends on whether the counter is rising or falling, which makes every pulse centred on the bottom of the ramp.

Software writes a threshold into a holding register. The threshold in force is taken from that holding register only when the counter sits at its ceiling, so a pulse never changes width halfway through. A two-bit output-mode code picks a non-inverting waveform, an inverting waveform, or no waveform at all. A pin-direction enable then decides whether the waveform reaches the pin driver. Two sticky flags report the bottom of the ramp and threshold hits. Each flag is cleared by writing a one to it.

Top module: `pc_pwm_timer`

## Requirements
- R1: While ticks arrive, `count_q` rises by one per tick from 0 to 255 and then falls by one per tick back to 0, repeating with a period of 510 ticks.
- R2: The values 255 and 0 each appear for exactly one tick. The tick taken at 255 yields 254, and the tick taken at 0 on the way back up yields 1.
- R3: `count_q`, the waveform and both flags change only on clock edges where `tick_en` is 1. Clearing a flag through `flag_clr` is the one exception.
- R4: With `out_mode` = 2 (non-inverting), a tick where the count equals the active threshold drives `pwm_out` to 0 if the count is rising and to 1 if it is falling. Over one period with threshold C, `pwm_out` is high for 2·C ticks.
- R5: With `out_mode` = 3 (inverting), a threshold hit while rising drives `pwm_out` to 1, and a hit while falling drives it to 0. `pwm_out` is high for 510 − 2·C ticks per period.
- R6: A write on `cmp_wr_en` fills a holding register only. The active threshold takes the held value on the tick taken while the count is 255. A hit at 255 on that same tick still uses the previous threshold.
- R7: With `out_mode` = 0 or 1, `pwm_out` keeps its value and `pin_drive` is 0. The counter and both flags keep running.
- R8: `pin_drive` equals `pwm_out` when `pin_dir_out` is 1 and `out_mode` is 2 or 3. Otherwise `pin_drive` is 0.
- R9: `ovf_flag` sets on the tick that moves the count from 1 to 0. `match_flag` sets on a tick where the count equals the active threshold.
- R10: Writing 1 to `flag_clr` bit 0 clears `ovf_flag`, and writing 1 to bit 1 clears `match_flag`. A clear in the same cycle as a set leaves the flag set.
- R11: In non-inverting mode, threshold 0 keeps `pwm_out` low for the whole period and threshold 255 keeps it high for the whole period.
- R12: Synchronous reset gives a count of 0 rising, `pwm_out` 0, both flags 0, and both threshold registers 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer tick from an external prescaler |
| cmp_wr_en | input | 1 | Write strobe for the threshold holding register |
| cmp_wr_data | input | 8 | Threshold value to hold |
| out_mode | input | 2 | 0/1 disconnected, 2 non-inverting, 3 inverting |
| pin_dir_out | input | 1 | 1 selects the pin as an output |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 match |
| count_q | output | 8 | Present counter value |
| pwm_out | output | 1 | Compare output register |
| pin_drive | output | 1 | Gated waveform toward the pin |
| ovf_flag | output | 1 | Sticky bottom-of-ramp flag |
| match_flag | output | 1 | Sticky threshold-hit flag |

## Verification
The waveform is swept across thresholds at both ends of the range, next to each end, and around the midpoint, in both the non-inverting and inverting codes. The high-time of each period is compared against 2·C or 510 − 2·C, which separates a correct direction-dependent action from a swapped or single-edge one. A threshold written in the middle of a period shows whether the new value takes effect early. Runs with irregular ticks, with the disconnected codes and with the pin disabled show that the count, the pin and the flags are each gated by the right input. Clears timed onto the exact tick of a set show which of the two wins.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

   typedef enum logic [1:0] {
      OM_OFF_A   = 2'd0,
      OM_OFF_B   = 2'd1,
      OM_NONINV  = 2'd2,
      OM_INV     = 2'd3
   } out_mode_e;

   localparam int FLAG_OVF  = 0;
   localparam int FLAG_CMP  = 1;
   localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/pcpwm_updown_ctr.sv
module pcpwm_updown_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             down,
   output logic             at_top,
   output logic             hit_bottom
);
   localparam logic [CNT_W-1:0] TOP  = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pcpwm_updown_ctr: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             down_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= ZERO;
         down_q <= 1'b0;
      end else if (tick) begin
         if (!down_q) begin
            cnt_q <= cnt_q + ONE;
            if (cnt_q == TOP - ONE) down_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) down_q <= 1'b0;
         end
      end
   end

   assign count      = cnt_q;
   assign down       = down_q;
   assign at_top     = (cnt_q == TOP);
   assign hit_bottom = tick && down_q && (cnt_q == ONE);

   // R1
   step_one_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));

   // R2
   top_turn_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q == TOP) |=> (cnt_q == TOP - ONE) && down_q);

   // R2
   bottom_turn_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && down_q && cnt_q == ONE) |=> (cnt_q == ZERO) && !down_q);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q) && $stable(down_q));

endmodule

// File: rtl/pcpwm_cmp_unit.sv
module pcpwm_cmp_unit #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             at_top,
   input  logic [CNT_W-1:0] count,
   input  logic             down,
   input  logic [1:0]       mode,
   output logic             match,
   output logic             wave
);
   import pcpwm_pkg::*;

   out_mode_e        md;
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] act_q;
   logic             wave_q;
   logic             drives;

   assign md     = out_mode_e'(mode);
   assign drives = (md == OM_NONINV) || (md == OM_INV);
   assign match  = tick && (count == act_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
      end else if (wr_en) begin
         hold_q <= wr_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= '0;
      end else if (tick && at_top) begin
         act_q <= hold_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wave_q <= 1'b0;
      end else if (match && drives) begin
         wave_q <= down ^ (md == OM_INV);
      end
   end

   assign wave = wave_q;

   // R4
   noninv_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (match && md == OM_NONINV && !down) |=> !wave_q);

   // R4
   noninv_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (match && md == OM_NONINV && down) |=> wave_q);

   // R5
   inv_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (match && md == OM_INV && !down) |=> wave_q);

   // R5
   inv_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (match && md == OM_INV && down) |=> !wave_q);

   // R6
   act_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(tick && at_top) |=> $stable(act_q));

   // R7
   off_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !drives |=> $stable(wave_q));

endmodule

// File: rtl/pcpwm_flag.sv
module pcpwm_flag (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   logic q_r;

   always_ff @(posedge clk) begin
      if (rst)      q_r <= 1'b0;
      else if (set) q_r <= 1'b1;
      else if (clr) q_r <= 1'b0;
   end

   assign q = q_r;

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set |=> q_r);

   // R10
   clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && !set) |=> !q_r);

endmodule

// File: rtl/pc_pwm_timer.sv
module pc_pwm_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             cmp_wr_en,
   input  logic [CNT_W-1:0] cmp_wr_data,
   input  logic [1:0]       out_mode,
   input  logic             pin_dir_out,
   input  logic [1:0]       flag_clr,
   output logic [CNT_W-1:0] count_q,
   output logic             pwm_out,
   output logic             pin_drive,
   output logic             ovf_flag,
   output logic             match_flag
);
   import pcpwm_pkg::*;

   logic                 ctr_down;
   logic                 ctr_top;
   logic                 ctr_bottom;
   logic                 cmp_hit;
   logic                 wave;
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_q;

   pcpwm_updown_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick_en),
      .count      (count_q),
      .down       (ctr_down),
      .at_top     (ctr_top),
      .hit_bottom (ctr_bottom)
   );

   pcpwm_cmp_unit #(.CNT_W(CNT_W)) cmp_i (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_en),
      .wr_en  (cmp_wr_en),
      .wr_val (cmp_wr_data),
      .at_top (ctr_top),
      .count  (count_q),
      .down   (ctr_down),
      .mode   (out_mode),
      .match  (cmp_hit),
      .wave   (wave)
   );

   assign flag_set[FLAG_OVF] = ctr_bottom;
   assign flag_set[FLAG_CMP] = cmp_hit;

   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         pcpwm_flag flag_i (
            .clk (clk),
            .rst (rst),
            .set (flag_set[g]),
            .clr (flag_clr[g]),
            .q   (flag_q[g])
         );
      end
   endgenerate

   assign ovf_flag   = flag_q[FLAG_OVF];
   assign match_flag = flag_q[FLAG_CMP];
   assign pwm_out    = wave;
   assign pin_drive  = pin_dir_out && out_mode[1] && wave;

   // R9
   ovf_at_bottom_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf_flag) |-> (count_q == '0));

   // R8
   pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
      pin_drive |-> (pwm_out && pin_dir_out));

   // R12
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (count_q == '0) && !pwm_out && !ovf_flag && !match_flag);

endmodule

// File: tb/pc_pwm_timer_tb.sv
`timescale 1ns/1ps
module pc_pwm_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       tick_en;
   logic       cmp_wr_en;
   logic [7:0] cmp_wr_data;
   logic [1:0] out_mode;
   logic       pin_dir_out;
   logic [1:0] flag_clr;
   logic [7:0] count_q;
   logic       pwm_out;
   logic       pin_drive;
   logic       ovf_flag;
   logic       match_flag;

   always #2 clk = ~clk;

   pc_pwm_timer dut_i (
      .clk         (clk),
      .rst         (rst),
      .tick_en     (tick_en),
      .cmp_wr_en   (cmp_wr_en),
      .cmp_wr_data (cmp_wr_data),
      .out_mode    (out_mode),
      .pin_dir_out (pin_dir_out),
      .flag_clr    (flag_clr),
      .count_q     (count_q),
      .pwm_out     (pwm_out),
      .pin_drive   (pin_drive),
      .ovf_flag    (ovf_flag),
      .match_flag  (match_flag)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;

   int    m_cnt;
   bit    m_down, m_out, m_ovf, m_mf;
   int    m_act, m_buf;
   string tag_w = "R4";
   string tag_f = "R9";

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(bit tk, bit we, int wd, logic [1:0] clr);
      bit mt;
      bit bot;
      tick_en     = tk;
      cmp_wr_en   = we;
      cmp_wr_data = wd[7:0];
      flag_clr    = clr;
      @(posedge clk);
      mt  = tk && (m_cnt == m_act);
      bot = tk && m_down && (m_cnt == 1);
      m_mf  = (m_mf  && !clr[1]) || mt;
      m_ovf = (m_ovf && !clr[0]) || bot;
      if (mt && out_mode[1]) m_out = m_down ^ out_mode[0];
      if (tk && m_cnt == 255) m_act = m_buf;
      if (tk) begin
         if (!m_down) begin
            m_cnt++;
            if (m_cnt == 255) m_down = 1'b1;
         end else begin
            m_cnt--;
            if (m_cnt == 0) m_down = 1'b0;
         end
      end
      if (we) m_buf = wd & 255;
      #1;
      chk("R1", count_q, m_cnt);
      chk(tag_w, pwm_out, m_out);
      chk("R8", pin_drive, pin_dir_out && out_mode[1] && m_out);
      chk(tag_f, ovf_flag, m_ovf);
      chk(tag_f, match_flag, m_mf);
      @(negedge clk);
      cmp_wr_en = 1'b0;
      flag_clr  = 2'b00;
   endtask

   task automatic run_to(int v);
      while (m_cnt != v) cyc(1, 0, 0, 2'b00);
   endtask

   task automatic sweep(int md, int c);
      int hi;
      int exp;
      out_mode = md[1:0];
      tag_w    = (md == 2) ? "R4" : "R5";
      cyc(1, 1, c, 2'b00);
      run_to(255);
      cyc(1, 0, 0, 2'b00);
      run_to(255);
      hi = 0;
      for (int i = 0; i < 510; i++) begin
         cyc(1, 0, 0, 2'b00);
         hi += pwm_out;
      end
      exp = (md == 2) ? 2 * c : 510 - 2 * c;
      if (md == 2 && (c == 0 || c == 255)) chk("R11", hi, exp);
      else chk(tag_w, hi, exp);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int vals[11] = '{0, 1, 2, 3, 64, 127, 128, 200, 253, 254, 255};
      logic held;
      rst = 1'b1; tick_en = 1'b0; cmp_wr_en = 1'b0; cmp_wr_data = '0;
      out_mode = 2'd2; pin_dir_out = 1'b1; flag_clr = 2'b00;
      m_cnt = 0; m_down = 0; m_out = 0; m_ovf = 0; m_mf = 0; m_act = 0; m_buf = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      chk("R12", count_q, 0);
      chk("R12", pwm_out, 0);
      chk("R12", ovf_flag, 0);
      chk("R12", match_flag, 0);
      chk("R12", pin_drive, 0);
      rst = 1'b0;

      // R3: no ticks, nothing moves
      repeat (20) cyc(0, 0, 0, 2'b00);
      chk("R3", count_q, 0);

      // R2: turnarounds
      run_to(255);
      chk("R2", count_q, 255);
      cyc(1, 0, 0, 2'b00);
      chk("R2", count_q, 254);
      run_to(0);
      chk("R2", count_q, 0);
      cyc(1, 0, 0, 2'b00);
      chk("R2", count_q, 1);

      // R4, R5, R11: threshold sweeps in both polarities
      foreach (vals[k]) sweep(2, vals[k]);
      foreach (vals[k]) sweep(3, vals[k]);

      // R6: mid-period write waits for the top of the ramp
      out_mode = 2'd2;
      tag_w    = "R6";
      cyc(1, 1, 255, 2'b00);
      run_to(255);
      cyc(1, 0, 0, 2'b00);
      run_to(0);
      run_to(100);
      cyc(1, 1, 10, 2'b00);
      run_to(255);
      cyc(1, 0, 0, 2'b00);
      chk("R6", pwm_out, 1);
      chk("R6", count_q, 254);
      run_to(9);
      chk("R6", pwm_out, 1);
      run_to(11);
      chk("R6", pwm_out, 0);

      // R7: disconnected codes
      tag_w = "R7";
      out_mode = 2'd0;
      held = pwm_out;
      cyc(0, 0, 0, 2'b11);
      repeat (520) cyc(1, 0, 0, 2'b00);
      chk("R7", pwm_out, held);
      chk("R7", pin_drive, 0);
      chk("R7", ovf_flag, 1);
      chk("R7", match_flag, 1);
      out_mode = 2'd1;
      repeat (300) cyc(1, 0, 0, 2'b00);
      chk("R7", pwm_out, held);

      // R8: pin disabled
      tag_w = "R8";
      out_mode = 2'd2;
      pin_dir_out = 1'b0;
      repeat (520) cyc(1, 0, 0, 2'b00);
      pin_dir_out = 1'b1;
      repeat (520) cyc(1, 0, 0, 2'b00);

      // R10: write-one-to-clear and set priority
      tag_f = "R10";
      cyc(0, 0, 0, 2'b11);
      chk("R10", ovf_flag, 0);
      chk("R10", match_flag, 0);
      while (!(m_down && m_cnt == 1)) cyc(1, 0, 0, 2'b00);
      cyc(1, 0, 0, 2'b01);
      chk("R10", ovf_flag, 1);
      run_to(5);
      cyc(1, 0, 0, 2'b10);
      chk("R10", match_flag, 0);
      run_to(10);
      cyc(1, 0, 0, 2'b10);
      chk("R10", match_flag, 1);
      tag_f = "R9";

      // R3: sparse ticks
      for (int i = 0; i < 900; i++) cyc((i % 3) == 0, 0, 0, 2'b00);
      chk("R3", count_q, m_cnt);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule